// File: doc/BRIEF.md
# Radix-2 Delay-Commutator FFT Stage (Interleaved Real/Imaginary Stream)

This block is one stage of a single-path radix-2 decimation-in-frequency pipelined FFT. Samples arrive one real word per accepted clock, the real part of each complex sample followed by its imaginary part. A block of the stream holds 2L complex samples, where L = N >> STAGE. The stage pairs sample j with sample j+L. It forms the halved sum and the halved difference of each pair, rotates the difference by a twiddle factor and sends the four resulting words out in the same interleaved format.

A single real add/sub unit produces one butterfly word on every accepted word. A single real multiplier forms one partial product on every accepted word. The four partial products of one complex rotation are spread over four consecutive words, and a post-adder joins them alternately by subtraction and by addition. Twiddle factors are computed at elaboration into a small constant table. The pipeline advances only on words flagged by `in_valid`, so idle cycles in the input leave the output sequence unchanged and only delay it.

Stages are chained by connecting `out_valid`/`out_data` of one stage to `in_valid`/`in_data` of the next, with STAGE counting up from 1.

Top module: `r2dc_stage`

## Requirements
- R1: Input words are counted from reset by acceptance (`in_valid` high). Word 2i of a block of 4L words is the real part of complex sample i, and word 2i+1 is its imaginary part. Blocks follow each other with no gap in the count. Sample j (j < L) is paired with sample j+L of the same block.
- R2: Output words 4j and 4j+1 of a block are the real and imaginary parts of floor((x[j] + x[j+L]) / 2), taken per component in two's complement.
- R3: Output words 4j+2 and 4j+3 are the real and imaginary parts of D·W. Here D = floor((x[j] − x[j+L]) / 2) per component. W = c + i·d, with c = round(cos(2πe/N)·2^(TW−2)), d = round(−sin(2πe/N)·2^(TW−2)) and e = j·2^(STAGE−1). Rounding is floor(v + 0.5).
- R4: The real part is computed from the exact value a·c − b·d and the imaginary part from a·d + b·c. Each is formed as floor((v + 2^(TW−3)) / 2^(TW−2)) and then saturated to the signed DW-bit range.
- R5: Output word q appears on `out_data`, with `out_valid` high for exactly one cycle, on the clock after the edge that accepts input word q + 2L + 7. `out_valid` is high on no other cycle.
- R6: On a cycle with `in_valid` low, nothing in the stage advances. On the following cycle `out_valid` is low and `out_data` keeps its value. Idle cycles do not change the output word sequence.
- R7: While `rst` is high, `out_valid` and `out_data` are cleared to zero on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Accept `in_data` on this edge |
| in_data | input | DW | Interleaved real/imaginary input word, two's complement |
| out_valid | output | 1 | `out_data` carries a new output word this cycle |
| out_data | output | DW | Interleaved real/imaginary output word, two's complement |

## Verification
The stage has very little observable state, so an internal fault shows at the ports within one block. If the phase or the pairing is wrong, the very first output block carries words from the wrong positions. If the multiplier schedule or the held operands slip, every rotated word in the block is wrong. Either fault shows about 2L + 7 accepted words after the faulty input, well inside the bench's first block. A fault in the acceptance gating shows as a shifted output index or a changed output during an idle cycle. Saturation and rounding errors are driven into view by a directed block with full-scale opposite operands and by several blocks of random words.

// File: rtl/r2dc_pkg.sv
package r2dc_pkg;
   // position of a word inside a four-word output group
   typedef enum logic [1:0] {
      PH_SUM_RE = 2'd0,
      PH_SUM_IM = 2'd1,
      PH_DIF_RE = 2'd2,
      PH_DIF_IM = 2'd3
   } phase_e;
endpackage

// File: rtl/r2dc_reorder.sv
// Holds two blocks of words and feeds the shared add/sub unit one operand pair per accepted word.
module r2dc_reorder
   import r2dc_pkg::*;
#(
   parameter int L  = 8,
   parameter int DW = 16,
   parameter int JW = 3
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 en,
   input  logic [DW-1:0]        din,
   output logic signed [DW-1:0] y,
   output phase_e               ph,
   output logic [JW-1:0]        pair
);
   localparam int DEPTH = 8 * L;
   localparam int AW    = $clog2(DEPTH);
   localparam int QW    = AW - 1;
   localparam int BASE  = 2 * L + 1;
   localparam logic [1:0] PH_INIT = 2'(DEPTH - BASE - 1);

   logic signed [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wcnt, rcnt, addr_a, addr_b;
   logic [QW-1:0] pos, off_a, off_b;
   logic signed [DW-1:0] opa, opb;
   logic signed [DW:0]   res;

   assign rcnt   = wcnt - AW'(BASE);
   assign pos    = rcnt[QW-1:0];
   assign off_a  = QW'((32'(pos) >> 2) * 2 + 32'(pos[0]));
   assign off_b  = off_a + QW'(2 * L);
   assign addr_a = {rcnt[AW-1], off_a};
   assign addr_b = {rcnt[AW-1], off_b};
   assign opa    = mem[addr_a];
   assign opb    = mem[addr_b];
   // one shared real add/sub: add for the two sum words, subtract for the two difference words
   assign res    = pos[1] ? ({opa[DW-1], opa} - {opb[DW-1], opb})
                          : ({opa[DW-1], opa} + {opb[DW-1], opb});

   always_ff @(posedge clk) begin
      if (rst) begin
         wcnt <= '0;
         y    <= '0;
         ph   <= phase_e'(PH_INIT);
         pair <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (en) begin
         wcnt      <= wcnt + AW'(1);
         mem[wcnt] <= din;
         y         <= res[DW:1];
         ph        <= phase_e'(pos[1:0]);
         pair      <= JW'(32'(pos) >> 2);
      end
   end

   // R1: operands are always words accepted on earlier edges, never the word arriving now
   p_no_fresh_read_r1 : assert property (@(posedge clk) disable iff (rst)
      en |-> (addr_a != wcnt && addr_b != wcnt));
endmodule

// File: rtl/r2dc_twiddle.sv
// Constant twiddle table, one entry per pair index, computed at elaboration.
module r2dc_twiddle #(
   parameter int N     = 16,
   parameter int STAGE = 1,
   parameter int TW    = 16,
   parameter int JW    = 3
) (
   input  logic [JW-1:0]        pair,
   output logic signed [TW-1:0] tw_c,
   output logic signed [TW-1:0] tw_d
);
   localparam int  ENTRIES = 2 ** JW;
   localparam real TWO_PI  = 6.283185307179586;
   localparam real SCALE   = 2.0 ** (TW - 2);

   logic signed [TW-1:0] ctab [ENTRIES];
   logic signed [TW-1:0] dtab [ENTRIES];

   for (genvar j = 0; j < ENTRIES; j++) begin : g_tab
      localparam int  EXPO = (j << (STAGE - 1)) % N;
      localparam real ANG  = TWO_PI * EXPO / N;
      localparam int  CV   = $rtoi($floor($cos(ANG) * SCALE + 0.5));
      localparam int  DV   = $rtoi($floor(-$sin(ANG) * SCALE + 0.5));
      assign ctab[j] = TW'(CV);
      assign dtab[j] = TW'(DV);
   end

   assign tw_c = ctab[pair];
   assign tw_d = dtab[pair];
endmodule

// File: rtl/r2dc_cmul.sv
// Rotates each difference pair with one real multiplier over four accepted words and aligns the sum words.
module r2dc_cmul
   import r2dc_pkg::*;
#(
   parameter int DW = 16,
   parameter int TW = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 en,
   input  logic signed [DW-1:0] y,
   input  phase_e               ph,
   input  logic signed [TW-1:0] tw_c,
   input  logic signed [TW-1:0] tw_d,
   output logic signed [DW-1:0] dout
);
   localparam int PW = DW + TW;
   localparam int SW = PW + 1;
   localparam logic signed [SW-1:0] MAXV = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [SW-1:0] MINV = ~MAXV;
   localparam logic signed [SW-1:0] HALF = SW'(1) << (TW - 3);

   logic signed [DW-1:0] y_d, ha, hb, sr, si, si2, re_hold;
   logic signed [TW-1:0] hc, hd;
   logic signed [DW-1:0] op_x;
   logic signed [TW-1:0] op_y;
   logic signed [PW-1:0] mult, prod, prev;
   logic signed [SW-1:0] acc, biased, shifted;
   logic signed [DW-1:0] rounded;

   // operand multiplexers: the data side alternates a,b and the twiddle side swaps c,d halfway
   always_comb begin
      unique case (ph)
         PH_SUM_RE: begin op_x = ha; op_y = hc; end
         PH_SUM_IM: begin op_x = hb; op_y = hd; end
         PH_DIF_RE: begin op_x = ha; op_y = hd; end
         default:   begin op_x = hb; op_y = hc; end
      endcase
   end

   assign mult = $signed({{TW{op_x[DW-1]}}, op_x}) * $signed({{DW{op_y[TW-1]}}, op_y});

   // post-adder: subtract when prod holds b*d, add when prod holds b*c
   assign acc     = (ph == PH_SUM_RE) ? ({prev[PW-1], prev} + {prod[PW-1], prod})
                                      : ({prev[PW-1], prev} - {prod[PW-1], prod});
   assign biased  = acc + HALF;
   assign shifted = biased >>> (TW - 2);
   assign rounded = (shifted > MAXV) ? DW'(MAXV) :
                    (shifted < MINV) ? DW'(MINV) : DW'(shifted);

   always_ff @(posedge clk) begin
      if (rst) begin
         y_d <= '0; ha <= '0; hb <= '0; hc <= '0; hd <= '0;
         prod <= '0; prev <= '0; sr <= '0; si <= '0; si2 <= '0;
         re_hold <= '0; dout <= '0;
      end else if (en) begin
         y_d  <= y;
         prod <= mult;
         prev <= prod;
         if (ph == PH_DIF_IM) begin
            ha <= y_d; hb <= y; hc <= tw_c; hd <= tw_d;
         end
         if (ph == PH_SUM_IM) begin
            sr <= y_d; si <= y; si2 <= si;
         end
         if (ph == PH_DIF_RE) re_hold <= rounded;
         unique case (ph)
            PH_SUM_IM: dout <= sr;
            PH_DIF_RE: dout <= si2;
            PH_DIF_IM: dout <= re_hold;
            default:   dout <= rounded;
         endcase
      end
   end

   // R1: the word phase coming from the reorder unit steps by exactly one per accepted word
   p_phase_step_r1 : assert property (@(posedge clk) disable iff (rst)
      en |=> (2'(ph) == 2'($past(ph) + 2'd1)));
   // R3: the held difference operands stay fixed while their four partial products are formed
   p_hold_operands_r3 : assert property (@(posedge clk) disable iff (rst)
      (en && ph != PH_DIF_IM) |=> ($stable(ha) && $stable(hb) && $stable(hc) && $stable(hd)));
endmodule

// File: rtl/r2dc_stage.sv
module r2dc_stage
   import r2dc_pkg::*;
#(
   parameter int N     = 16,
   parameter int STAGE = 1,
   parameter int DW    = 16,
   parameter int TW    = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   output logic          out_valid,
   output logic [DW-1:0] out_data
);
   localparam int LOGN = $clog2(N);
   localparam int L    = N >> STAGE;
   localparam int JW   = (L > 1) ? $clog2(L) : 1;
   localparam int LAT  = 2 * L + 7;
   localparam int CW   = $clog2(LAT + 1);

   if (N < 4 || (1 << LOGN) != N) begin : g_bad_n
      $error("r2dc_stage: N must be a power of two of at least 4");
   end
   if (STAGE < 1 || STAGE > LOGN) begin : g_bad_stage
      $error("r2dc_stage: STAGE must lie in 1..log2(N)");
   end
   if (DW < 4 || TW < 4) begin : g_bad_width
      $error("r2dc_stage: DW and TW must be at least 4");
   end

   logic signed [DW-1:0] y, dout;
   phase_e               ph;
   logic [JW-1:0]        pair;
   logic signed [TW-1:0] tw_c, tw_d;
   logic [CW-1:0]        seen;

   r2dc_reorder #(.L(L), .DW(DW), .JW(JW)) u_reorder (
      .clk(clk), .rst(rst), .en(in_valid), .din(in_data),
      .y(y), .ph(ph), .pair(pair)
   );

   r2dc_twiddle #(.N(N), .STAGE(STAGE), .TW(TW), .JW(JW)) u_twiddle (
      .pair(pair), .tw_c(tw_c), .tw_d(tw_d)
   );

   r2dc_cmul #(.DW(DW), .TW(TW)) u_cmul (
      .clk(clk), .rst(rst), .en(in_valid), .y(y), .ph(ph),
      .tw_c(tw_c), .tw_d(tw_d), .dout(dout)
   );

   assign out_data = dout;

   always_ff @(posedge clk) begin
      if (rst) begin
         seen      <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid && (seen == CW'(LAT));
         if (in_valid && seen != CW'(LAT)) seen <= seen + CW'(1);
      end
   end

   // R5: a valid output word always follows an accepted input word
   p_valid_follows_r5 : assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid));
   // R6: an idle input cycle freezes the output
   p_idle_freeze_r6 : assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && $stable(out_data)));
   // R7: reset clears the output side
   p_reset_clear_r7 : assert property (@(posedge clk)
      rst |=> (!out_valid && out_data == '0));
endmodule

// File: tb/r2dc_stage_bench.sv
module r2dc_stage_bench;
   localparam int PERIOD = 10;
   localparam int N      = 16;
   localparam int STAGE  = 1;
   localparam int DW     = 16;
   localparam int TW     = 16;
   localparam int L      = N >> STAGE;
   localparam int BLK    = 4 * L;
   localparam int NBLK   = 12;
   localparam int W      = NBLK * BLK;
   localparam int LAT    = 2 * L + 7;
   localparam int MAXV   = (1 << (DW - 1)) - 1;
   localparam int MINV   = -(1 << (DW - 1));

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          out_valid;
   logic [DW-1:0] out_data;

   int checks = 0;
   int fails  = 0;
   int stim [W];
   int expv [W];
   int oidx = 0;
   int accepted = 0;
   int last_out = 0;
   bit done = 1'b0;

   r2dc_stage #(.N(N), .STAGE(STAGE), .DW(DW), .TW(TW)) u_r2dc_stage (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data)
   );

   always #(PERIOD / 2) clk = ~clk;

   always @(posedge clk) if (!rst && in_valid) accepted <= accepted + 1;

   task automatic check(input bit ok, input string req, input int act, input int exp_v);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (output word %0d)", req, act, exp_v, oidx);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   function automatic int sat_round(input longint v);
      longint t;
      t = (v + (64'sd1 <<< (TW - 3))) >>> (TW - 2);
      if (t > MAXV) return MAXV;
      if (t < MINV) return MINV;
      return int'(t);
   endfunction

   function automatic int tw_val(input int j, input bit sine);
      real ang;
      ang = 6.283185307179586 * ((j << (STAGE - 1)) % N) / N;
      if (sine) return $rtoi($floor(-$sin(ang) * (2.0 ** (TW - 2)) + 0.5));
      return $rtoi($floor($cos(ang) * (2.0 ** (TW - 2)) + 0.5));
   endfunction

   // behavioural decimation-in-frequency stage over one block
   task automatic model_block(input int b);
      int base, xr0, xi0, xr1, xi1, a, bb, c, d;
      base = b * BLK;
      for (int j = 0; j < L; j++) begin
         xr0 = stim[base + 2*j];       xi0 = stim[base + 2*j + 1];
         xr1 = stim[base + 2*(j+L)];   xi1 = stim[base + 2*(j+L) + 1];
         expv[base + 4*j]     = (xr0 + xr1) >>> 1;
         expv[base + 4*j + 1] = (xi0 + xi1) >>> 1;
         a  = (xr0 - xr1) >>> 1;
         bb = (xi0 - xi1) >>> 1;
         c  = tw_val(j, 1'b0);
         d  = tw_val(j, 1'b1);
         expv[base + 4*j + 2] = sat_round(longint'(a) * c - longint'(bb) * d);
         expv[base + 4*j + 3] = sat_round(longint'(a) * d + longint'(bb) * c);
      end
   endtask

   // output monitor, sampling away from the active edge
   always @(negedge clk) begin
      if (!rst && !done) begin
         if (out_valid) begin
            if (oidx < W) begin
               if ((oidx % 4) < 2)
                  check($signed(out_data) == expv[oidx], "R2 (R1 pairing) sum word", $signed(out_data), expv[oidx]);
               else
                  check($signed(out_data) == expv[oidx], "R3/R4 rotated difference", $signed(out_data), expv[oidx]);
               check(accepted == oidx + LAT + 1, "R5 latency", accepted, oidx + LAT + 1);
            end
            last_out = $signed(out_data);
            oidx++;
         end else if (oidx > 0) begin
            check($signed(out_data) == last_out, "R6 hold while idle", $signed(out_data), last_out);
         end
      end
   end

   initial begin
      #(PERIOD * 100000);
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      int seed_set;
      seed_set = $urandom(32'h51ce);
      // block 0: full-scale opposite operands (saturation on rotated pairs)
      for (int i = 0; i < L; i++) begin
         stim[2*i] = MAXV; stim[2*i+1] = MAXV;
         stim[2*(i+L)] = MINV; stim[2*(i+L)+1] = MINV;
      end
      // block 1: single impulse
      for (int i = 0; i < BLK; i++) stim[BLK + i] = 0;
      stim[BLK] = 1000; stim[BLK + 1] = -500;
      // block 2: every word at the most negative value
      for (int i = 0; i < BLK; i++) stim[2*BLK + i] = MINV;
      for (int i = 3 * BLK; i < W; i++) stim[i] = int'($signed(16'($urandom)));
      for (int b = 0; b < NBLK; b++) model_block(b);

      repeat (3) @(negedge clk);
      // R7: reset state at the ports
      check(out_valid == 1'b0, "R7 reset valid", int'(out_valid), 0);
      check(out_data == '0, "R7 reset data", $signed(out_data), 0);
      rst = 1'b0;

      for (int w = 0; w < W; w++) begin
         if (w >= 3 * BLK && ($urandom % 4) == 0) begin
            in_valid = 1'b0;
            repeat (1 + $urandom % 3) @(negedge clk);
         end
         in_valid = 1'b1;
         in_data  = DW'(stim[w]);
         @(negedge clk);
      end
      in_valid = 1'b0;
      repeat (6) @(negedge clk);
      done = 1'b1;
      // R5: exactly one output word per accepted word beyond the latency
      check(oidx == W - LAT, "R5 output count", oidx, W - LAT);
      finish_run();
   end
endmodule